// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Selectable Deselect Timing

This block is a small synchronous SRAM with a pipelined read path. Every command input is captured on the rising clock edge: the three chip selects, the word address, the global write strobe, the byte-write strobe, the four lane enables and the write data. The stored word is 36 bits wide and is split into four 9-bit lanes. A captured read is executed one edge later into a registered output stage, so read data reaches the pins two edges after the command.

The output drivers are modelled as a data bus plus a separate drive-enable output that an enclosing pad ring would use as its tri-state control. Drive is gated without a clock by the active-low output enable and by the sleep input. A mode input picks how quickly the drivers release after a deselect. In single-stage mode the drivers let go as soon as the deselect has been captured. In two-stage mode the deselect follows the read pipeline, so data from a read that came just before it stays on the bus for one more cycle.

A write command can either store all lanes at once, through the global strobe, or store only a chosen set of lanes, through the byte-write strobe and the lane enables. While sleep is high, new commands are dropped and the array keeps its contents. The mode input should be tied high when the single-stage behaviour, which is the normal one, is wanted.

Top module: `sram_dsel_top`

## Requirements
- R1: A command is accepted only on an edge where `ce1_n` is 0, `ce2` is 1 and `ce3_n` is 0. If any of the three is in its other state, the command is treated as a deselect: nothing is written and nothing is read.
- R2: A read accepted on edge k drives the stored word on `q_data` with `q_drive` high after edge k+1. This assumes the command captured on edge k+1 does not turn the drivers off.
- R3: `gwr_n` = 0 on an accepted command writes all four lanes, whatever `bwr_n` and `lane_n` are.
- R4: With `gwr_n` = 1 and `bwr_n` = 0, lane i (bits 9i+8..9i) is written exactly when `lane_n[i]` = 0. If all four `lane_n` bits are 1, the cycle is a read.
- R5: With `gwr_n` = 1 and `bwr_n` = 1, the cycle is a read that returns all 36 bits, whatever `lane_n` is.
- R6: While an accepted write sits in the input stage (the cycle after it is captured), `q_drive` is 0.
- R7: With `single_dsel` = 1, `q_drive` is 0 in the cycle after a deselect is captured.
- R8: With `single_dsel` = 0, a deselect captured right after a read keeps that read's data driven for one cycle. `q_drive` falls only after the next edge.
- R9: `oe_n` = 1 forces `q_drive` to 0 without waiting for a clock edge, and `oe_n` = 0 restores drive the same way.
- R10: While `sleep` = 1, `q_drive` is 0 and commands are ignored. Stored data is kept across sleep.
- R11: After a synchronous reset (`rst_n` = 0 at an edge), `q_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| addr | input | ADDR_W | Word address |
| gwr_n | input | 1 | Global write strobe, active low |
| bwr_n | input | 1 | Byte-write strobe, active low |
| lane_n | input | LANES | Lane enables for byte writes, active low |
| wdata | input | WORD_W | Write data |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Low-power request, active high |
| single_dsel | input | 1 | 1 = single-stage deselect, 0 = two-stage deselect |
| q_data | output | WORD_W | Read data, zero when not driven |
| q_drive | output | 1 | Tri-state drive enable for q_data |

## Verification
Two events can fall in the same cycle. One is the output stage presenting data from the previous read. The other is the input stage holding a newer command that wants the bus released, either a deselect or a write. The bench sends a read followed immediately by a deselect in both deselect modes, and sends a read followed by a write, so that the release decision and the pending read data meet in one cycle. It judges each such cycle against a behavioural model that tracks both stages and checks both the drive enable and the data value. The asynchronous output enable is also toggled in the middle of a cycle that is already driving, and sleep is raised while a write is presented.

// File: rtl/sram_dsel_pkg.sv
// Shared constants and command encoding for the pipelined SRAM.
package sram_dsel_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;

    // Command held in the input stage after capture.
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;
endpackage

// File: rtl/sram_cmd_decode.sv
// Combinational decode of the raw command pins into a command and a lane
// write mask. Assumes the inputs are stable around the capture edge; the
// caller registers the result. Sleep suppresses every command.
module sram_cmd_decode
    import sram_dsel_pkg::*;
#(
    parameter int LANES = sram_dsel_pkg::LANES
) (
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             sleep,
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_n,
    output cmd_e             cmd,
    output logic [LANES-1:0] lane_we
);
    logic selected;
    logic any_lane;

    // Purpose: decide the command class and which lanes a write touches.
    always_comb begin
        selected = !ce1_n && ce2 && !ce3_n && !sleep;
        any_lane = |(~lane_n);
        cmd      = CMD_IDLE;
        lane_we  = '0;
        if (selected) begin
            if (!gwr_n) begin
                cmd     = CMD_WRITE;
                lane_we = '1;
            end else if (!bwr_n && any_lane) begin
                cmd     = CMD_WRITE;
                lane_we = ~lane_n;
            end else begin
                cmd = CMD_READ;
            end
        end
    end
endmodule

// File: rtl/sram_lane_array.sv
// Storage array split into independent lanes, each with its own write
// enable. Writes happen on the rising edge; reads are combinational from
// the registered read address. Contents are not reset.
module sram_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Purpose: store this lane's slice when its enable is set.
        always_ff @(posedge clk) begin
            if (we[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/sram_out_stage.sv
// Registered output stage and drive-enable logic. Assumes the input stage
// command is presented one edge after capture. Drive needs valid read data
// in this stage, no write pending in the input stage, and (in single-stage
// mode) a read pending in the input stage. oe_n and sleep gate drive
// combinationally.
module sram_out_stage
    import sram_dsel_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              s1_cmd,
    input  logic [WORD_W-1:0] arr_rdata,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic              single_dsel,
    output logic [WORD_W-1:0] q_data,
    output logic              q_drive
);
    logic              out_valid;
    logic [WORD_W-1:0] out_q;
    logic              pipe_ok;

    // Purpose: mark whether the output register holds fresh read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= (s1_cmd == CMD_READ);
        end
    end

    // Purpose: load the array word for a read executing this edge.
    always_ff @(posedge clk) begin
        if (s1_cmd == CMD_READ) begin
            out_q <= arr_rdata;
        end
    end

    // Purpose: combine pipeline state with the asynchronous gates.
    always_comb begin
        pipe_ok = single_dsel ? (s1_cmd == CMD_READ) : (s1_cmd != CMD_WRITE);
        q_drive = out_valid && pipe_ok && !oe_n && !sleep;
        q_data  = q_drive ? out_q : '0;
    end
endmodule

// File: rtl/sram_dsel_top.sv
// Pipelined synchronous SRAM top. Stage 1 registers the decoded command,
// address and data; the following edge performs the write or loads the
// output register. Assumes single_dsel is static during operation.
module sram_dsel_top
    import sram_dsel_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = sram_dsel_pkg::LANES,
    parameter int LANE_W = sram_dsel_pkg::LANE_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              gwr_n,
    input  logic              bwr_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [WORD_W-1:0] wdata,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic              single_dsel,
    output logic [WORD_W-1:0] q_data,
    output logic              q_drive
);
    cmd_e              dec_cmd;
    logic [LANES-1:0]  dec_we;
    cmd_e              s1_cmd;
    logic [LANES-1:0]  s1_we;
    logic [ADDR_W-1:0] s1_addr;
    logic [WORD_W-1:0] s1_wdata;
    logic [WORD_W-1:0] arr_rdata;

    sram_cmd_decode #(.LANES(LANES)) u_decode (
        .ce1_n  (ce1_n),
        .ce2    (ce2),
        .ce3_n  (ce3_n),
        .sleep  (sleep),
        .gwr_n  (gwr_n),
        .bwr_n  (bwr_n),
        .lane_n (lane_n),
        .cmd    (dec_cmd),
        .lane_we(dec_we)
    );

    // Purpose: input stage capturing the decoded command on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_cmd <= CMD_IDLE;
            s1_we  <= '0;
        end else begin
            s1_cmd <= dec_cmd;
            s1_we  <= dec_we;
        end
    end

    // Purpose: capture address and write data alongside the command.
    always_ff @(posedge clk) begin
        s1_addr  <= addr;
        s1_wdata <= wdata;
    end

    sram_lane_array #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_array (
        .clk  (clk),
        .we   (s1_we),
        .waddr(s1_addr),
        .wdata(s1_wdata),
        .raddr(s1_addr),
        .rdata(arr_rdata)
    );

    sram_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_cmd     (s1_cmd),
        .arr_rdata  (arr_rdata),
        .oe_n       (oe_n),
        .sleep      (sleep),
        .single_dsel(single_dsel),
        .q_data     (q_data),
        .q_drive    (q_drive)
    );

    // Port-level view of what the pins request this cycle, for the checks.
    logic pin_sel, pin_wr, pin_rd, pin_idle;
    assign pin_sel  = !ce1_n && ce2 && !ce3_n && !sleep;
    assign pin_wr   = pin_sel && (!gwr_n || (!bwr_n && !(&lane_n)));
    assign pin_rd   = pin_sel && !pin_wr;
    assign pin_idle = !pin_sel;

    // R6: a captured write releases the bus in the following cycle.
    a_r6_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
        pin_wr |=> !q_drive);

    // R7: single-stage mode releases right after a deselect is captured.
    a_r7_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        (single_dsel && pin_idle) |=> (!q_drive || !single_dsel));

    // R8: two-stage mode keeps the previous read on the bus one more cycle.
    a_r8_dual_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_dsel && pin_idle && !sleep && !oe_n && $past(rst_n) && $past(pin_rd))
        |=> (q_drive || oe_n || sleep || single_dsel));

    // R9: output enable high means no drive.
    a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !q_drive);

    // R10: sleep means no drive.
    a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !q_drive);
endmodule

// File: tb/sram_dsel_top_tb.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module sram_dsel_top_tb;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int WW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce1_n, ce2, ce3_n;
    logic [AW-1:0] addr;
    logic          gwr_n, bwr_n;
    logic [NL-1:0] lane_n;
    logic [WW-1:0] wdata;
    logic          oe_n, sleep, single_dsel;
    logic [WW-1:0] q_data;
    logic          q_drive;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    logic [LW-1:0] m_mem [0:(1<<AW)-1][0:NL-1];
    int            m_cmd = 0;   // 0 idle, 1 read, 2 write
    logic [NL-1:0] m_we  = '0;
    logic [AW-1:0] m_addr = '0;
    logic [WW-1:0] m_wd = '0;
    bit            m_outv = 0;
    logic [WW-1:0] m_out = '0;

    sram_dsel_top #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .addr(addr), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n),
        .wdata(wdata), .oe_n(oe_n), .sleep(sleep), .single_dsel(single_dsel),
        .q_data(q_data), .q_drive(q_drive)
    );

    always #5 clk = ~clk;

    task automatic model_edge();
        bit sel;
        if (m_cmd == 2)
            for (int i = 0; i < NL; i++)
                if (m_we[i]) m_mem[m_addr][i] = m_wd[i*LW +: LW];
        m_outv = (m_cmd == 1);
        if (m_cmd == 1)
            for (int i = 0; i < NL; i++) m_out[i*LW +: LW] = m_mem[m_addr][i];
        sel = !ce1_n && ce2 && !ce3_n && !sleep;
        m_addr = addr;
        m_wd   = wdata;
        m_we   = '0;
        if (!sel) m_cmd = 0;
        else if (!gwr_n) begin m_cmd = 2; m_we = '1; end
        else if (!bwr_n && lane_n != '1) begin m_cmd = 2; m_we = ~lane_n; end
        else m_cmd = 1;
        if (!rst_n) begin m_cmd = 0; m_we = '0; m_outv = 0; end
    endtask

    function automatic bit exp_drive();
        bit ok;
        ok = single_dsel ? (m_cmd == 1) : (m_cmd != 2);
        return m_outv && ok && !oe_n && !sleep;
    endfunction

    task automatic cmp_model(string tag);
        bit ed;
        ed = exp_drive();
        n_tests++;
        if (q_drive !== ed || (ed && q_data !== m_out)) begin
            n_fail++;
            $display("FAIL %s model: drive=%0b data=%h expected drive=%0b data=%h",
                     tag, q_drive, q_data, ed, m_out);
        end
    endtask

    task automatic expect_out(string tag, bit drv, logic [WW-1:0] val);
        n_tests++;
        if (q_drive !== drv || (drv && q_data !== val)) begin
            n_fail++;
            $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                     tag, q_drive, q_data, drv, val);
        end
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        model_edge();
        #2;
        cmp_model(tag);
    endtask

    task automatic do_idle();
        ce1_n = 1; ce2 = 0; ce3_n = 1; gwr_n = 1; bwr_n = 1; lane_n = '1;
    endtask

    task automatic do_sel();
        ce1_n = 0; ce2 = 1; ce3_n = 0;
    endtask

    task automatic do_gw(logic [AW-1:0] a, logic [WW-1:0] d);
        do_sel(); addr = a; wdata = d; gwr_n = 0; bwr_n = 1; lane_n = '1;
    endtask

    task automatic do_bw(logic [AW-1:0] a, logic [WW-1:0] d, logic [NL-1:0] ln);
        do_sel(); addr = a; wdata = d; gwr_n = 1; bwr_n = 0; lane_n = ln;
    endtask

    task automatic do_rd(logic [AW-1:0] a, logic [NL-1:0] ln, logic bw);
        do_sel(); addr = a; gwr_n = 1; bwr_n = bw; lane_n = ln;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    localparam logic [WW-1:0] A1 = 36'h1_2345_6789;
    localparam logic [WW-1:0] A2 = 36'hA_BCDE_F012;
    localparam logic [WW-1:0] A3 = 36'h5_A5A5_A5A5;
    localparam logic [WW-1:0] BB = 36'hF_FFFF_FFFF;
    localparam logic [WW-1:0] CC = 36'h0_0000_0000;
    // addr 2 after byte write with lane_n=1010: lanes 0 and 2 from BB, 1 and 3 from A2
    logic [WW-1:0] merged;

    initial begin
        merged = A2;
        merged[0*LW +: LW] = BB[0*LW +: LW];
        merged[2*LW +: LW] = BB[2*LW +: LW];

        rst_n = 0; oe_n = 0; sleep = 0; single_dsel = 1; addr = '0; wdata = '0;
        do_idle();
        for (int i = 0; i < 3; i++) begin
            cyc("R11");
            expect_out("R11", 1'b0, '0);
        end
        rst_n = 1;

        // Writes: global, global overriding lanes, byte-lane write
        do_gw(1, A1);                 cyc("R3");
        do_gw(2, A2); bwr_n = 0; lane_n = 4'b0101; cyc("R3");
        do_gw(3, A3);                 cyc("R3");
        do_bw(2, BB, 4'b1010);        cyc("R4");
        expect_out("R6", 1'b0, '0);

        // R1: each chip select wrong in turn, attempted overwrite of addr 1
        do_gw(1, CC); ce1_n = 1;      cyc("R1");
        do_gw(1, CC); ce2 = 0;        cyc("R1");
        do_gw(1, CC); ce3_n = 1;      cyc("R1");

        // Back-to-back reads in single-stage mode
        do_rd(1, 4'b0000, 1'b1);      cyc("R2");
        do_rd(2, 4'b0000, 1'b1);      cyc("R5");
        expect_out("R1", 1'b1, A1);   // read of addr 1 driven: A1 unchanged
        do_rd(3, 4'b1111, 1'b0);      cyc("R4");
        expect_out("R4", 1'b1, merged);
        do_idle();                    cyc("R7");
        expect_out("R7", 1'b0, '0);
        cyc("R7");
        expect_out("R7", 1'b0, '0);

        // Two-stage deselect
        single_dsel = 0;
        do_rd(1, 4'b1111, 1'b1);      cyc("R8");
        do_rd(2, 4'b1111, 1'b1);      cyc("R8");
        expect_out("R2", 1'b1, A1);
        do_idle();                    cyc("R8");
        expect_out("R8", 1'b1, merged);
        cyc("R8");
        expect_out("R8", 1'b0, '0);

        // Read followed by write, both modes
        do_rd(3, 4'b1111, 1'b1);      cyc("R6");
        do_rd(3, 4'b1111, 1'b1);      cyc("R6");
        do_gw(4, A1);                 cyc("R6");
        expect_out("R6", 1'b0, '0);
        single_dsel = 1;
        do_rd(3, 4'b1111, 1'b1);      cyc("R6");
        do_rd(3, 4'b1111, 1'b1);      cyc("R6");
        do_gw(5, A2);                 cyc("R6");
        expect_out("R6", 1'b0, '0);

        // Asynchronous output enable
        do_rd(1, 4'b1111, 1'b1);      cyc("R9");
        do_rd(1, 4'b1111, 1'b1);      cyc("R9");
        expect_out("R9", 1'b1, A1);
        oe_n = 1; #1;
        expect_out("R9", 1'b0, '0);
        oe_n = 0; #1;
        expect_out("R9", 1'b1, A1);

        // Sleep: drive off, write ignored, data kept
        do_rd(3, 4'b1111, 1'b1);      cyc("R10");
        sleep = 1; #1;
        expect_out("R10", 1'b0, '0);
        do_gw(3, CC);                 cyc("R10");
        expect_out("R10", 1'b0, '0);
        cyc("R10");
        sleep = 0;
        do_rd(3, 4'b1111, 1'b1);      cyc("R10");
        do_rd(3, 4'b1111, 1'b1);      cyc("R10");
        expect_out("R10", 1'b1, A3);
        do_idle();                    cyc("R7");
        cyc("R7");

        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end
endmodule